// File: doc/BRIEF.md
# Self-Correcting Oscillator Calibration Controller

This block supervises a crystal-oscillator phase-locked loop from the digital side. After reset, it picks a 4-bit coarse centre-frequency code for the oscillator. It does so with a binary search that counts oscillator pulses against a fixed window of reference cycles. It can also pick the code again after lock is lost. When the search ends, it waits a bounded time for the loop's lock indication and then holds the code.

Two inputs change this behaviour. A manual-override input skips calibration and passes a 4-bit manual code straight to the oscillator. A restart-enable input decides whether a loss of lock starts a new search. Every bit of controller state is kept in three copies. The copies are majority-voted every cycle, and the voted value is written back to all three. A lone upset is therefore removed within one clock, and a flag shows the disagreement while it lasts.

Top module: `cal_ctrl`

## Requirements
- R1: While `rst_n` is low (sampled on `clk`), the stored code is forced to 4'b1000. After release, a new search starts and, with `ext_ctrl` low, `vco_code` stays 4'b1000 for the whole first measurement window.
- R2: While `ext_ctrl` is 1, `vco_code` equals `man_sel` in the same cycle and no search runs. The cycle after `ext_ctrl` returns to 0, a fresh search starts with code 4'b1000.
- R3: While `ext_ctrl` is 0, changes on `man_sel` do not alter `vco_code`.
- R4: The search tests bit 3 first and bit 0 last, using one window of WIN_LEN cycles per bit. The trial bit is set at the start of its window and cleared at the end if more than TARGET `osc_tick` pulses were counted. The final code is the largest code whose count is at most TARGET, or 0 if there is none, and it is ready 4×WIN_LEN cycles after the search starts.
- R5: After the search, the controller waits up to LOCK_WAIT cycles for `lock_det`. Once lock is seen, the code is held unchanged for as long as lock remains.
- R6: With `auto_rst` at 1, a new search starts (code back to 4'b1000 in the next cycle) in two cases: `lock_det` falls while the code is held, or the LOCK_WAIT window expires without lock.
- R7: With `auto_rst` at 0, neither a loss of lock nor an expired wait window changes the code; only reset or the override path starts a search.
- R8: `locked` equals `lock_det` in the same cycle under every control setting.
- R9: An upset of any single state copy (modelled by a one-hot `seu_inject`) leaves `vco_code` unchanged. `seu_err` is 1 for exactly the one cycle in which the copies disagree and then returns to 0 by itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset; starts a search |
| ext_ctrl | input | 1 | Manual override of the oscillator code |
| auto_rst | input | 1 | Enables a new search after loss of lock |
| man_sel | input | 4 | Manual oscillator code used under override |
| lock_det | input | 1 | Lock indication from the analog loop |
| osc_tick | input | 1 | One pulse per divided oscillator cycle, synchronous to clk |
| seu_inject | input | 3 | Inverts one state copy at the next edge to model an upset |
| vco_code | output | 4 | Coarse oscillator frequency code |
| locked | output | 1 | Current lock status |
| seu_err | output | 1 | State copies disagree this cycle |

## Verification
The upset checks assume that at most one copy is struck in a given cycle and that strikes are at least two cycles apart. The bench injects only one-hot values, one cycle at a time, with idle cycles in between. The oscillator model in the bench derives `osc_tick` from the current `vco_code` through a fractional accumulator. This keeps the pulse count in each window exactly equal to the modelled rate, so the search result can be computed in advance. `lock_det` is driven only between measurement windows or while the code is being held.

// File: rtl/calctl_pkg.sv
package calctl_pkg;
    localparam int CODE_W    = 4;
    localparam int WIN_LEN   = 16;
    localparam int LOCK_WAIT = 32;
    localparam int WIN_W     = $clog2(WIN_LEN);
    localparam int CNT_W     = $clog2(WIN_LEN + 1);
    localparam int WAIT_W    = $clog2(LOCK_WAIT);
    localparam int IDX_W     = $clog2(CODE_W);

    typedef enum logic [1:0] {
        PH_SEARCH = 2'd0,
        PH_SETTLE = 2'd1,
        PH_HOLD   = 2'd2,
        PH_MANUAL = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [CODE_W-1:0]   code;
        logic [IDX_W-1:0]    idx;
        logic [WIN_W-1:0]    win;
        logic [CNT_W-1:0]    cnt;
        logic [WAIT_W-1:0]   wait_c;
    } ctl_st_t;

    localparam int ST_W = $bits(ctl_st_t);

    function automatic ctl_st_t search_start();
        ctl_st_t s;
        s        = '0;
        s.phase  = PH_SEARCH;
        s.code   = CODE_W'(1) << (CODE_W - 1);
        s.idx    = IDX_W'(CODE_W - 1);
        return s;
    endfunction

    function automatic logic [ST_W-1:0] vote3(input logic [ST_W-1:0] a,
                                              input logic [ST_W-1:0] b,
                                              input logic [ST_W-1:0] c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/tmr_store.sv
module tmr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic [W-1:0] d,
    input  logic [2:0]   inj,
    output logic [W-1:0] q,
    output logic         mismatch
);
    import calctl_pkg::*;

    logic [2:0][W-1:0] cps;

    for (genvar i = 0; i < 3; i++) begin : g_copy
        logic [W-1:0] r;
        always_ff @(posedge clk) begin
            if (!rst_n)      r <= rst_val;
            else if (inj[i]) r <= ~d;
            else             r <= d;
        end
        assign cps[i] = r;
    end

    assign q        = vote3(cps[0], cps[1], cps[2]);
    assign mismatch = (cps[0] != cps[1]) || (cps[0] != cps[2]);
endmodule

// File: rtl/cal_next.sv
module cal_next #(
    parameter int TARGET = 10
) (
    input  calctl_pkg::ctl_st_t cur,
    input  logic                ext_ctrl,
    input  logic                auto_rst,
    input  logic                lock_det,
    input  logic                osc_tick,
    output calctl_pkg::ctl_st_t nxt
);
    import calctl_pkg::*;

    logic [CNT_W-1:0]  fin;
    logic [CODE_W-1:0] code_t;

    always_comb begin
        nxt    = cur;
        fin    = cur.cnt + CNT_W'(osc_tick);
        code_t = cur.code;
        if (ext_ctrl) begin
            nxt.phase = PH_MANUAL;
        end else begin
            case (cur.phase)
                PH_MANUAL: nxt = search_start();
                PH_SEARCH: begin
                    if (cur.win == WIN_W'(WIN_LEN - 1)) begin
                        if (fin > CNT_W'(TARGET)) code_t[cur.idx] = 1'b0;
                        nxt.win = '0;
                        nxt.cnt = '0;
                        if (cur.idx == '0) begin
                            nxt.phase  = PH_SETTLE;
                            nxt.wait_c = '0;
                        end else begin
                            nxt.idx = cur.idx - IDX_W'(1);
                            code_t[cur.idx - IDX_W'(1)] = 1'b1;
                        end
                        nxt.code = code_t;
                    end else begin
                        nxt.win = cur.win + WIN_W'(1);
                        nxt.cnt = fin;
                    end
                end
                PH_SETTLE: begin
                    if (lock_det) begin
                        nxt.phase = PH_HOLD;
                    end else if (cur.wait_c == WAIT_W'(LOCK_WAIT - 1)) begin
                        if (auto_rst) nxt = search_start();
                        else          nxt.phase = PH_HOLD;
                    end else begin
                        nxt.wait_c = cur.wait_c + WAIT_W'(1);
                    end
                end
                default: begin
                    if (!lock_det && auto_rst) nxt = search_start();
                end
            endcase
        end
    end
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl #(
    parameter int TARGET = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_ctrl,
    input  logic       auto_rst,
    input  logic [3:0] man_sel,
    input  logic       lock_det,
    input  logic       osc_tick,
    input  logic [2:0] seu_inject,
    output logic [3:0] vco_code,
    output logic       locked,
    output logic       seu_err
);
    import calctl_pkg::*;

    localparam ctl_st_t ST_RST = search_start();

    ctl_st_t         st_q;
    ctl_st_t         st_d;
    logic [ST_W-1:0] q_bits;
    phase_e          phase_q;

    tmr_store #(.W(ST_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_val  (ST_RST),
        .d        (st_d),
        .inj      (seu_inject),
        .q        (q_bits),
        .mismatch (seu_err)
    );

    assign st_q    = ctl_st_t'(q_bits);
    assign phase_q = st_q.phase;

    cal_next #(.TARGET(TARGET)) u_next (
        .cur      (st_q),
        .ext_ctrl (ext_ctrl),
        .auto_rst (auto_rst),
        .lock_det (lock_det),
        .osc_tick (osc_tick),
        .nxt      (st_d)
    );

    assign vco_code = ext_ctrl ? man_sel : st_q.code;
    assign locked   = lock_det;
endmodule

// File: rtl/cal_ctrl_chk.sv
module cal_ctrl_chk
    import calctl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ext_ctrl,
    input logic       auto_rst,
    input logic       lock_det,
    input logic [2:0] seu_inject,
    input logic       seu_err,
    input logic [3:0] vco_code,
    input phase_e     phase_q
);
    AST_RESET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) && !ext_ctrl |-> vco_code == 4'b1000); // R1
    AST_EXT_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ctrl |=> phase_q == PH_MANUAL); // R2
    AST_EXT_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_MANUAL && !ext_ctrl |=> (ext_ctrl || vco_code == 4'b1000)); // R2
    AST_UNLOCK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_HOLD && auto_rst && !lock_det && !ext_ctrl |=> phase_q == PH_SEARCH); // R6
    AST_NO_AUTO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_HOLD && !auto_rst && !ext_ctrl |=> phase_q != PH_SEARCH); // R7
    AST_UPSET_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(seu_inject) |=> seu_err); // R9
    AST_UPSET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        seu_err && seu_inject == 3'b000 |=> !seu_err); // R9
endmodule

bind cal_ctrl cal_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_ctrl   (ext_ctrl),
    .auto_rst   (auto_rst),
    .lock_det   (lock_det),
    .seu_inject (seu_inject),
    .seu_err    (seu_err),
    .vco_code   (vco_code),
    .phase_q    (phase_q)
);

// File: tb/sim_cal_ctrl.sv
module sim_cal_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_ctrl = 1'b0;
    logic       auto_rst = 1'b1;
    logic [3:0] man_sel = 4'b1000;
    logic       lock_det = 1'b0;
    logic       osc_tick = 1'b0;
    logic [2:0] seu_inject = 3'b000;
    logic [3:0] vco_code;
    logic       locked;
    logic       seu_err;

    int checks = 0;
    int failures = 0;
    int offset = 0;
    int acc = 0;

    localparam int NV = 7;
    localparam int VEC_OFF [NV] = '{0, 1, -3, -8, 12, 5, 3};
    localparam int VEC_EXP [NV] = '{10, 9, 13, 15, 0, 5, 7};

    always #4 clk = ~clk;

    cal_ctrl #(.TARGET(10)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_ctrl(ext_ctrl), .auto_rst(auto_rst),
        .man_sel(man_sel), .lock_det(lock_det), .osc_tick(osc_tick),
        .seu_inject(seu_inject), .vco_code(vco_code), .locked(locked),
        .seu_err(seu_err)
    );

    // oscillator model: pulses per 16-cycle window equal clamp(code + offset)
    always @(posedge clk) begin
        int rate;
        #1;
        rate = int'(vco_code) + offset;
        if (rate < 0)  rate = 0;
        if (rate > 16) rate = 16;
        acc = acc + rate;
        if (acc >= 16) begin
            osc_tick = 1'b1;
            acc = acc - 16;
        end else begin
            osc_tick = 1'b0;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(2);
        chk("R1 code in reset", vco_code, 8);
        chk("R9 no error in reset", seu_err, 0);

        // R4: vector walk over oscillator offsets
        for (int v = 0; v < NV; v++) begin
            offset = VEC_OFF[v];
            do_reset();
            cyc(2);
            chk("R1 first window code", vco_code, 8);
            cyc(68);
            chk("R4 search result", vco_code, VEC_EXP[v]);
            chk("R8 locked low", locked, 0);
        end

        // R5/R8: lock acquired during wait, code held
        offset = 0;
        do_reset();
        cyc(66);
        lock_det = 1'b1;
        #1;
        chk("R8 locked follows", locked, 1);
        cyc(150);
        chk("R5 code held while locked", vco_code, 10);

        // R3: manual select ignored without override
        man_sel = 4'b0011;
        cyc(3);
        chk("R3 man_sel ignored", vco_code, 10);

        // R9: single upsets
        seu_inject = 3'b001;
        cyc(1);
        seu_inject = 3'b000;
        #1;
        chk("R9 flag raised", seu_err, 1);
        chk("R9 code kept", vco_code, 10);
        cyc(1);
        chk("R9 flag cleared", seu_err, 0);
        cyc(2);
        seu_inject = 3'b100;
        cyc(1);
        seu_inject = 3'b000;
        cyc(1);
        chk("R9 flag cleared copy2", seu_err, 0);
        chk("R9 code kept copy2", vco_code, 10);

        // R6: unlock restarts search
        lock_det = 1'b0;
        cyc(1);
        chk("R6 restart on unlock", vco_code, 8);
        chk("R8 locked low", locked, 0);
        cyc(68);
        chk("R6 research result", vco_code, 10);
        cyc(30);
        chk("R6 restart on wait timeout", vco_code, 8);

        // R7: no restart with auto_rst low
        auto_rst = 1'b0;
        offset = 1;
        do_reset();
        cyc(110);
        chk("R7 timeout keeps code", vco_code, 9);
        lock_det = 1'b1;
        cyc(2);
        lock_det = 1'b0;
        cyc(20);
        chk("R7 unlock keeps code", vco_code, 9);
        chk("R8 locked low", locked, 0);

        // R2: override path
        ext_ctrl = 1'b1;
        man_sel = 4'b0101;
        #1;
        chk("R2 override code", vco_code, 5);
        cyc(120);
        man_sel = 4'b1110;
        #1;
        chk("R2 override follows", vco_code, 14);
        ext_ctrl = 1'b0;
        cyc(1);
        chk("R2 resume starts search", vco_code, 8);
        cyc(69);
        chk("R2 resume search result", vco_code, 9);

        // R1: reset mid-operation
        rst_n = 1'b0;
        cyc(1);
        chk("R1 reset mid-run", vco_code, 8);
        rst_n = 1'b1;
        cyc(2);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule